// File: doc/BRIEF.md
# Single-Pass Raster Object Labeller

This block gives every foreground pixel of a one-bit image an object number while the image streams past in raster order, left to right and top to bottom, with no second pass. Each incoming pixel comes with a valid strobe and markers for the start of a line, the start of a frame and the last pixel of a frame. One cycle later the block emits that pixel's label. Background pixels get label 0.

Only two row-length pieces of state are kept: the labels written for the previous row, and a small window over the current row (the label to the left, plus the saved upper-left value). When a foreground pixel has no labelled neighbour, it takes the next free number. Otherwise it inherits a number that is already there. Objects that turn out later to be connected may therefore carry several numbers; resolving those is left to a later stage. At frame end the block reports how many numbers were handed out. A sticky flag records that the 8-bit label space ran out.

Top module: `raster_labeller`

## Requirements
- R1: Each input cycle with `pix_valid` high produces exactly one output cycle with `lbl_valid` high on the next clock. A cycle without `pix_valid` produces `lbl_valid` low on the next clock and changes no state.
- R2: A background pixel (`pix_bit` = 0) is given label 0.
- R3: A foreground pixel whose left neighbour on the same row carries a non-zero label takes that label, even when a smaller label sits above it.
- R4: A foreground pixel with no labelled left neighbour takes the smallest non-zero label among the upper-left, upper and upper-right pixels of the previous row of the same frame.
- R5: A foreground pixel with none of those four neighbours labelled is given a new label equal to the number of labels allocated so far in the frame plus one, so the first new label of a frame is 1.
- R6: Labels are 8 bits wide. Once 255 labels have been allocated, a further request yields label 255 and sets `overflow`. `overflow` stays set until the first pixel of the next frame, which clears it unless that pixel overflows itself.
- R7: The first pixel of a line (`pix_sol` or `pix_sof`) has no left neighbour. Pixels of the first row of a frame (`pix_sof`) have no upper neighbours. The start of a frame resets the allocation count to zero.
- R8: The clock after a pixel with `pix_eof` set, `count_valid` is high for one cycle and `count_out` holds the number of labels allocated in that frame, saturating at 255.
- R9: After reset, `lbl_valid`, `lbl_out`, `overflow`, `count_valid` and `count_out` are all 0.
- R10: Column 0 has no upper-left neighbour. Upper or upper-right positions at or beyond the length of the previous row count as unlabelled, so rows of different lengths are handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_valid | input | 1 | Input pixel strobe |
| pix_bit | input | 1 | Pixel value, 1 = object |
| pix_sol | input | 1 | Pixel is first of its line |
| pix_sof | input | 1 | Pixel is first of the frame (also starts a line) |
| pix_eof | input | 1 | Pixel is last of the frame |
| lbl_valid | output | 1 | Output label strobe |
| lbl_out | output | 8 | Label of the pixel accepted the clock before |
| overflow | output | 1 | Sticky label-space exhaustion flag for the current frame |
| count_valid | output | 1 | One-cycle pulse after the frame's last pixel |
| count_out | output | 8 | Labels allocated in the finished frame |

## Verification
The bench targets these corner cases:
- **Left-versus-above precedence.** A design that took the overall minimum would relabel the tail of a run whenever a smaller number appeared above it.
- **Column edges.** An unguarded upper-right read past a shorter previous row would pick up stale labels from an earlier, longer row.
- **Line and frame boundaries.** A design that kept the left label across a line start, or the previous row across a frame start, would merge unrelated objects.
- **Label exhaustion.** A frame of isolated dots forces more than 255 allocations. Wrapping the counter instead of saturating would reissue small numbers, and a non-sticky flag would drop after one pixel.
- **Recovery after exhaustion.** The frame that follows must restart at label 1 with the flag clear.

// File: rtl/lbl_pkg.sv
package lbl_pkg;
    localparam int LBL_W = 8;
    localparam logic [LBL_W-1:0] LBL_MAX = {LBL_W{1'b1}};
    typedef logic [LBL_W-1:0] label_t;

    // smaller of two labels, treating 0 as "none"
    function automatic label_t min_nz(label_t a, label_t b);
        if (a == '0) return b;
        if (b == '0) return a;
        return (a < b) ? a : b;
    endfunction
endpackage

// File: rtl/lbl_linebuf.sv
module lbl_linebuf
    import lbl_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_a_addr,
    output label_t        rd_a_data,
    input  logic [AW-1:0] rd_b_addr,
    output label_t        rd_b_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  label_t        wr_data
);
    label_t mem_q [DEPTH];

    assign rd_a_data = mem_q[rd_a_addr];
    assign rd_b_data = mem_q[rd_b_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end
endmodule

// File: rtl/lbl_pick.sv
module lbl_pick
    import lbl_pkg::*;
(
    input  logic   fg,
    input  label_t left,
    input  label_t up_left,
    input  label_t up,
    input  label_t up_right,
    input  label_t used,
    output label_t label,
    output logic   alloc,
    output logic   sat
);
    label_t above;

    always_comb begin
        above = min_nz(min_nz(up_left, up), up_right);
        label = '0;
        alloc = 1'b0;
        sat   = 1'b0;
        if (fg) begin
            if (left != '0) begin
                label = left;
            end else if (above != '0) begin
                label = above;
            end else if (used == LBL_MAX) begin
                label = LBL_MAX;
                sat   = 1'b1;
            end else begin
                label = used + 1'b1;
                alloc = 1'b1;
            end
        end
    end

    // R2: background never labelled; R5: fresh labels only when no neighbour
    always_comb begin
        if (!fg) assert (label == '0) else $error("p_bg_zero_r2");
        if (alloc) assert (left == '0 && above == '0) else $error("p_fresh_r5");
    end
endmodule

// File: rtl/raster_labeller.sv
module raster_labeller
    import lbl_pkg::*;
#(
    parameter int ROW_MAX = 64,
    localparam int AW    = (ROW_MAX > 1) ? $clog2(ROW_MAX) : 1,
    localparam int COL_W = $clog2(ROW_MAX + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pix_valid,
    input  logic         pix_bit,
    input  logic         pix_sol,
    input  logic         pix_sof,
    input  logic         pix_eof,
    output logic         lbl_valid,
    output logic [LBL_W-1:0] lbl_out,
    output logic         overflow,
    output logic         count_valid,
    output logic [LBL_W-1:0] count_out
);
    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [COL_W-1:0] plen;
        label_t           left;
        label_t           ul;
        label_t           used;
        logic             ovf;
        label_t           lbl;
        logic             lbl_vld;
        label_t           cnt;
        logic             cnt_vld;
    } state_t;

    state_t st_d, st_q;

    logic             sol, sof;
    logic [COL_W-1:0] col_cur, col_nxt, plen_cur;
    logic             up_ok, ur_ok;
    label_t           rd_up, rd_ur, up_v, ur_v, ul_v, left_v, used_cur;
    label_t           new_lbl;
    logic             alloc, sat;
    logic [AW-1:0]    addr_up, addr_ur;

    always_comb begin
        sof      = pix_sof;
        sol      = pix_sol | pix_sof;
        col_cur  = sol ? '0 : st_q.col;
        col_nxt  = col_cur + 1'b1;
        plen_cur = sof ? '0 : (pix_sol ? st_q.col : st_q.plen);
        up_ok    = col_cur < plen_cur;
        ur_ok    = col_nxt < plen_cur;
        addr_up  = AW'(col_cur);
        addr_ur  = ur_ok ? AW'(col_nxt) : AW'(col_cur);
        up_v     = up_ok ? rd_up : '0;
        ur_v     = ur_ok ? rd_ur : '0;
        ul_v     = sol ? '0 : st_q.ul;
        left_v   = sol ? '0 : st_q.left;
        used_cur = sof ? '0 : st_q.used;
    end

    lbl_linebuf #(.DEPTH(ROW_MAX)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_addr (addr_up),
        .rd_a_data (rd_up),
        .rd_b_addr (addr_ur),
        .rd_b_data (rd_ur),
        .wr_en     (pix_valid),
        .wr_addr   (addr_up),
        .wr_data   (new_lbl)
    );

    lbl_pick u_pick (
        .fg       (pix_bit),
        .left     (left_v),
        .up_left  (ul_v),
        .up       (up_v),
        .up_right (ur_v),
        .used     (used_cur),
        .label    (new_lbl),
        .alloc    (alloc),
        .sat      (sat)
    );

    always_comb begin
        st_d         = st_q;
        st_d.lbl_vld = 1'b0;
        st_d.cnt_vld = 1'b0;
        if (pix_valid) begin
            st_d.col     = col_nxt;
            st_d.plen    = plen_cur;
            st_d.ul      = up_v;
            st_d.left    = new_lbl;
            st_d.used    = alloc ? used_cur + 1'b1 : used_cur;
            st_d.ovf     = (sof ? 1'b0 : st_q.ovf) | sat;
            st_d.lbl     = new_lbl;
            st_d.lbl_vld = 1'b1;
            if (pix_eof) begin
                st_d.cnt     = st_d.used;
                st_d.cnt_vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lbl_valid   = st_q.lbl_vld;
    assign lbl_out     = st_q.lbl;
    assign overflow    = st_q.ovf;
    assign count_valid = st_q.cnt_vld;
    assign count_out   = st_q.cnt;

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> lbl_valid);
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !lbl_valid && $stable(lbl_out));
    p_bg_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && !pix_bit |=> lbl_out == '0);
    p_run_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && pix_bit && !pix_sol && !pix_sof && lbl_out != '0
        |=> lbl_out == $past(lbl_out));
    p_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lbl_valid |-> lbl_out <= st_q.used);
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !(pix_valid && pix_sof) |=> overflow);
    p_cnt_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && pix_eof |=> count_valid && count_out == st_q.used);
endmodule

// File: tb/raster_labeller_bench.sv
module raster_labeller_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       pix_valid, pix_bit, pix_sol, pix_sof, pix_eof;
    logic       lbl_valid, overflow, count_valid;
    logic [7:0] lbl_out, count_out;

    always #4 clk = ~clk;

    raster_labeller u_raster_labeller (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_bit(pix_bit),
        .pix_sol(pix_sol), .pix_sof(pix_sof), .pix_eof(pix_eof),
        .lbl_valid(lbl_valid), .lbl_out(lbl_out), .overflow(overflow),
        .count_valid(count_valid), .count_out(count_out)
    );

    int checks = 0;
    int errors = 0;
    int img [0:39][0:63];
    int lab [0:39][0:63];
    int wid [0:39];
    int m_used;
    bit m_ovf;
    bit done = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int mnz(int a, int b);
        if (a == 0) return b;
        if (b == 0) return a;
        return (a < b) ? a : b;
    endfunction

    // reference labelling of pixel (r,c) from the requirements
    function automatic int ref_label(int r, int c);
        int left, best;
        if (img[r][c] == 0) return 0;                     // R2
        left = (c > 0) ? lab[r][c-1] : 0;                 // R7 no left at line start
        if (left != 0) return left;                       // R3
        best = 0;
        for (int k = c - 1; k <= c + 1; k++)              // R4, R10
            if (r > 0 && k >= 0 && k < wid[r-1]) best = mnz(best, lab[r-1][k]);
        if (best != 0) return best;
        if (m_used < 255) begin m_used++; return m_used; end  // R5
        m_ovf = 1; return 255;                            // R6
    endfunction

    task automatic idle();
        pix_valid = 0; pix_bit = 0; pix_sol = 0; pix_sof = 0; pix_eof = 0;
        @(negedge clk);
        chk(lbl_valid == 0, "R1 idle", lbl_valid, 0);
    endtask

    task automatic run_frame(int nrows, int gap_pct);
        m_used = 0; m_ovf = 0;
        for (int r = 0; r < nrows; r++) begin
            for (int c = 0; c < wid[r]; c++) begin
                int e;
                bit last;
                if (gap_pct > 0 && ($urandom % 100) < gap_pct) idle();
                e = ref_label(r, c);
                lab[r][c] = e;
                last = (r == nrows - 1) && (c == wid[r] - 1);
                pix_valid = 1; pix_bit = img[r][c][0];
                pix_sol = (c == 0); pix_sof = (r == 0 && c == 0); pix_eof = last;
                @(negedge clk);
                chk(lbl_valid == 1, "R1 valid", lbl_valid, 1);
                chk(lbl_out == e[7:0], "R3/R4/R5 label", lbl_out, e);
                chk(overflow == m_ovf, "R6 overflow", overflow, m_ovf);
                chk(count_valid == last, "R8 pulse", count_valid, last);
                if (last) chk(count_out == m_used, "R8 count", count_out, m_used);
            end
        end
        idle();
        chk(count_valid == 0, "R8 one cycle", count_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 0; pix_valid = 0; pix_bit = 0; pix_sol = 0; pix_sof = 0; pix_eof = 0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(lbl_valid == 0 && lbl_out == 0, "R9 label", lbl_out, 0);
        chk(overflow == 0, "R9 overflow", overflow, 0);
        chk(count_valid == 0 && count_out == 0, "R9 count", count_out, 0);
        rst_n = 1;
        idle();

        // directed R3 vs R4: run under a smaller label keeps its left label
        wid[0] = 8; wid[1] = 8;
        for (int c = 0; c < 8; c++) begin img[0][c] = 0; img[1][c] = 0; end
        img[0][6] = 1;                              // label 1
        img[1][1] = 1; img[1][2] = 1; img[1][3] = 1; img[1][4] = 1;
        img[1][5] = 1;                              // R3: 2 across, despite 1 above c5
        run_frame(2, 0);

        // directed R10: longer row after a shorter one, then a long one again
        wid[0] = 12; wid[1] = 5; wid[2] = 12;
        for (int c = 0; c < 12; c++) begin img[0][c] = 1; img[1][c] = 0; img[2][c] = 0; end
        img[2][0] = 1; img[2][7] = 1; img[2][11] = 1;   // R10 beyond short row: new labels
        run_frame(3, 0);

        // R6 exhaustion: isolated dots, more than 255
        for (int r = 0; r < 34; r++) begin
            wid[r] = 32;
            for (int c = 0; c < 32; c++) img[r][c] = (r % 2 == 0 && c % 2 == 0) ? 1 : 0;
        end
        run_frame(34, 0);
        // R6/R7 recovery: next frame restarts at 1 with flag clear
        wid[0] = 4; img[0][0] = 0; img[0][1] = 1; img[0][2] = 0; img[0][3] = 0;
        run_frame(1, 0);

        // random frames with varying widths, density and gaps
        for (int f = 0; f < 12; f++) begin
            int dens = 20 + ($urandom % 60);
            int nr = 4 + ($urandom % 16);
            for (int r = 0; r < nr; r++) begin
                wid[r] = 1 + ($urandom % 64);
                for (int c = 0; c < wid[r]; c++) img[r][c] = (($urandom % 100) < dens) ? 1 : 0;
            end
            run_frame(nr, (f % 3 == 0) ? 15 : 0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule